// File: doc/BRIEF.md
# Single-Channel Cycle-Stealing DMA Engine

This block moves a block of words between one peripheral and main memory over a shared system bus, without the processor copying each word. Software loads a device port number, a memory start address and a word count, then writes a control word that picks the direction and starts the channel. From then on the engine takes the bus one word at a time. For each word it waits until the device says it has data ready, raises a bus request, waits for the grant and spends exactly one bus cycle moving the word. In that cycle the word goes straight from device to memory, or from memory to device. It then gives the bus back. The processor is never interrupted by this theft: it only stalls if it needs the bus in a cycle the engine holds.

Because the engine sits on the bus next to the device, each word costs a single bus cycle. The memory address steps forward by one word and the remaining count drops by one after each move. When the count is exhausted the channel goes idle and raises an interrupt line. The line stays high until software clears it.

Top module: `steal_dma`

## Requirements
- R1: After reset the channel is idle (status busy bit 0), the interrupt is low, no bus request or transfer is driven, and the device, memory and count registers read 0.
- R2: The register port has four word addresses. Address 0 is control on write (bit 0 start, bit 1 direction with 1 meaning memory to device, bit 2 interrupt clear) and status on read (bit 0 busy, bit 1 direction, bit 2 interrupt pending). Address 1 is the device port number, address 2 the current memory address and address 3 the remaining word count. Addresses 1 to 3 read back what was written while the channel is idle.
- R3: Writing start while idle latches the direction bit and reads busy from the next cycle until the block completes.
- R4: A bus request is raised only when the device ready input was high while the channel waited between words. With ready low the request stays low and the count does not change.
- R5: Each transfer cycle (busXfer high) follows a cycle in which request and grant were both high. During it the bus carries the current memory address, the device port and the latched direction.
- R6: Each grant moves exactly one word. In the cycle after a transfer the request is low, so the bus is released between words.
- R7: After every transfer the memory address grows by ADDR_STEP (default 4) and the remaining count falls by 1.
- R8: When the remaining count is 0, busy clears and the interrupt rises on the same clock edge.
- R9: The interrupt holds until a write to address 0 with bit 2 set clears it.
- R10: While busy, a start write is ignored (the direction and the transfer sequence are unchanged), and writes to addresses 1 to 3 are ignored.
- R11: Starting with a count of 0 completes one cycle after the start write, without any bus request, and sets the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data, combinational from regAddr |
| devReady | input | 1 | Device has a word ready or can accept one |
| busGrant | input | 1 | Bus grant from the arbiter |
| busReq | output | 1 | Bus request |
| busXfer | output | 1 | Single-cycle word transfer strobe |
| busDir | output | 1 | 1: memory to device, 0: device to memory |
| busDevAddr | output | DEV_W | Device port number for the transfer |
| busMemAddr | output | DATA_W | Memory address for the transfer |
| irq | output | 1 | Block-complete interrupt |

## Verification
The case that is hardest to reach from the ports is the gap between two words of a running block. In that gap the device can withdraw readiness and software can write a new start or new parameters. Both must leave the pending sequence intact. The bench reaches this gap by counting the transfer strobes its monitor has seen. It drops device ready right after the second word and holds it low. While the channel is parked with words still owed, it issues the conflicting writes, checks the read-back, then restores readiness and lets the scoreboard confirm the remaining addresses.

// File: rtl/steal_dma_pkg.sv
package steal_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_REQ  = 2'd2,
    ST_XFER = 2'd3
  } dmaState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic step;
  } dpStrobe_t;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_DEV  = 2'd1;
  localparam logic [1:0] REG_MEM  = 2'd2;
  localparam logic [1:0] REG_CNT  = 2'd3;

  localparam int BIT_GO  = 0;
  localparam int BIT_DIR = 1;
  localparam int BIT_CLR = 2;

endpackage

// File: rtl/steal_dma_ctrl.sv
module steal_dma_ctrl
  import steal_dma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      regWrEn,
  input  logic [1:0] regAddr,
  input  logic      goBit,
  input  logic      clrBit,
  input  logic      devReady,
  input  logic      busGrant,
  input  logic      countZero,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      irq,
  output logic      busReq,
  output logic      busXfer
);

  dmaState_t state, stateNext;
  logic ctrlWr;
  logic startReq;
  logic blockDone;

  assign ctrlWr    = regWrEn && (regAddr == REG_CTRL);
  assign busy      = (state != ST_IDLE);
  assign startReq  = ctrlWr && goBit && !busy;
  assign blockDone = (state == ST_WAIT) && countZero;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startReq) stateNext = ST_WAIT;
      ST_WAIT: begin
        if (countZero)     stateNext = ST_IDLE;
        else if (devReady) stateNext = ST_REQ;
      end
      ST_REQ:  if (busGrant) stateNext = ST_XFER;
      ST_XFER: stateNext = ST_WAIT;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                irq <= 1'b0;
    else if (blockDone)       irq <= 1'b1;
    else if (ctrlWr && clrBit) irq <= 1'b0;
  end

  assign busReq           = (state == ST_REQ) || (state == ST_XFER);
  assign busXfer          = (state == ST_XFER);
  assign strobe.loadStart = startReq;
  assign strobe.step      = (state == ST_XFER);

  // R6: the bus is released in the cycle after every word
  a_r6_release_after_word: assert property (@(posedge clk) disable iff (!rstN)
    busXfer |=> !busReq);

  // R5: a transfer cycle only follows request and grant together
  a_r5_xfer_after_grant: assert property (@(posedge clk) disable iff (!rstN)
    busXfer |-> $past(busReq && busGrant));

  // R4: a new request needs the device to have been ready
  a_r4_req_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> $past(devReady));

  // R8: completion raises the interrupt
  a_r8_done_sets_irq: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> irq);

  // R9: interrupt holds until cleared
  a_r9_irq_held: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(ctrlWr && clrBit)) |=> irq);

endmodule

// File: rtl/steal_dma_dp.sv
module steal_dma_dp
  import steal_dma_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DEV_W     = 8,
  parameter int CNT_W     = 16,
  parameter int ADDR_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              busy,
  input  logic              irq,
  input  dpStrobe_t         strobe,
  output logic [DATA_W-1:0] regRdData,
  output logic              countZero,
  output logic [DATA_W-1:0] busMemAddr,
  output logic [DEV_W-1:0]  busDevAddr,
  output logic              busDir
);

  localparam logic [DATA_W-1:0] STEP_INC = DATA_W'(ADDR_STEP);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic [DEV_W-1:0]  devPort;
  logic [DATA_W-1:0] memAddr;
  logic [CNT_W-1:0]  wordsLeft;
  logic              dirToDev;
  logic              idleWr;

  assign idleWr = regWrEn && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devPort <= '0;
    end else if (idleWr && regAddr == REG_DEV) begin
      devPort <= regWrData[DEV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr <= '0;
    end else if (strobe.step) begin
      memAddr <= memAddr + STEP_INC;
    end else if (idleWr && regAddr == REG_MEM) begin
      memAddr <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordsLeft <= '0;
    end else if (strobe.step) begin
      wordsLeft <= wordsLeft - CNT_ONE;
    end else if (idleWr && regAddr == REG_CNT) begin
      wordsLeft <= regWrData[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 dirToDev <= 1'b0;
    else if (strobe.loadStart) dirToDev <= regWrData[BIT_DIR];
  end

  assign countZero  = (wordsLeft == '0);
  assign busMemAddr = memAddr;
  assign busDevAddr = devPort;
  assign busDir     = dirToDev;

  always_comb begin
    unique case (regAddr)
      REG_CTRL: regRdData = DATA_W'({irq, dirToDev, busy});
      REG_DEV:  regRdData = DATA_W'(devPort);
      REG_MEM:  regRdData = memAddr;
      default:  regRdData = DATA_W'(wordsLeft);
    endcase
  end

  // R7: each word advances the address and consumes one count
  a_r7_step_update: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (memAddr == $past(memAddr) + STEP_INC) &&
                    (wordsLeft == $past(wordsLeft) - CNT_ONE));

  // R7: a step never happens with nothing left
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> !countZero);

  // R10: direction and device port frozen while busy
  a_r10_dir_stable: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(dirToDev) && $stable(devPort));

endmodule

// File: rtl/steal_dma.sv
module steal_dma
  import steal_dma_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DEV_W     = 8,
  parameter int CNT_W     = 16,
  parameter int ADDR_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              devReady,
  input  logic              busGrant,
  output logic              busReq,
  output logic              busXfer,
  output logic              busDir,
  output logic [DEV_W-1:0]  busDevAddr,
  output logic [DATA_W-1:0] busMemAddr,
  output logic              irq
);

  dpStrobe_t strobe;
  logic      busy;
  logic      countZero;

  steal_dma_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .goBit    (regWrData[BIT_GO]),
    .clrBit   (regWrData[BIT_CLR]),
    .devReady (devReady),
    .busGrant (busGrant),
    .countZero(countZero),
    .strobe   (strobe),
    .busy     (busy),
    .irq      (irq),
    .busReq   (busReq),
    .busXfer  (busXfer)
  );

  steal_dma_dp #(
    .DATA_W   (DATA_W),
    .DEV_W    (DEV_W),
    .CNT_W    (CNT_W),
    .ADDR_STEP(ADDR_STEP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .busy      (busy),
    .irq       (irq),
    .strobe    (strobe),
    .regRdData (regRdData),
    .countZero (countZero),
    .busMemAddr(busMemAddr),
    .busDevAddr(busDevAddr),
    .busDir    (busDir)
  );

endmodule

// File: tb/tb_steal_dma.sv
module tb_steal_dma;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int DEV_W  = 8;

  typedef struct {
    logic [DATA_W-1:0] mem;
    logic [DEV_W-1:0]  dev;
    logic              dir;
  } xferItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [1:0]        regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic              devReady = 1'b1;
  logic              busGrant = 1'b0;
  logic              busReq, busXfer, busDir, irq;
  logic [DEV_W-1:0]  busDevAddr;
  logic [DATA_W-1:0] busMemAddr;

  int testsRun = 0;
  int testsFailed = 0;
  int xferCount = 0;
  int grantDelay = 0;
  xferItem_t expQ[$];

  steal_dma dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .devReady(devReady),
    .busGrant(busGrant), .busReq(busReq), .busXfer(busXfer), .busDir(busDir),
    .busDevAddr(busDevAddr), .busMemAddr(busMemAddr), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [DATA_W-1:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [DATA_W-1:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  // driver: program a block and push the expected words
  task automatic launchJob(input logic dir, input logic [DEV_W-1:0] dev,
                           input logic [DATA_W-1:0] mem, input int n);
    regWrite(2'd1, DATA_W'(dev));
    regWrite(2'd2, mem);
    regWrite(2'd3, DATA_W'(n));
    for (int i = 0; i < n; i++) begin
      xferItem_t it;
      it.mem = mem + DATA_W'(4 * i);
      it.dev = dev;
      it.dir = dir;
      expQ.push_back(it);
    end
    regWrite(2'd0, DATA_W'({dir, 1'b1}));
  endtask

  task automatic waitIrq(input string req);
    int n = 0;
    while (!irq && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(irq === 1'b1, req, "interrupt after block", irq, 1);
  endtask

  // bus arbiter model
  initial begin
    int waited = 0;
    forever begin
      @(negedge clk);
      if (busReq && !busXfer) begin
        if (waited >= grantDelay) busGrant = 1'b1;
        else waited++;
      end else begin
        busGrant = 1'b0;
        waited = 0;
      end
    end
  end

  // monitor and scoreboard
  initial begin
    bit prevXfer = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (prevXfer) check(busReq === 1'b0, "R6", "request after word", busReq, 0);
        if (busXfer) begin
          xferCount++;
          if (expQ.size() == 0) begin
            check(1'b0, "R5", "unexpected transfer", busMemAddr, 0);
          end else begin
            xferItem_t e;
            e = expQ.pop_front();
            check(busMemAddr === e.mem, "R5", "transfer memory address", busMemAddr, e.mem);
            check(busDevAddr === e.dev, "R5", "transfer device port", busDevAddr, e.dev);
            check(busDir === e.dir, "R5", "transfer direction", busDir, e.dir);
          end
        end
        prevXfer = busXfer;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    testsRun++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] v;
    int base;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(2'd0, v); check(v === 0, "R1", "status after reset", v, 0);
    check(irq === 1'b0, "R1", "irq after reset", irq, 0);
    check(busReq === 1'b0 && busXfer === 1'b0, "R1", "bus idle after reset", busReq, 0);
    regRead(2'd2, v); check(v === 0, "R1", "memory address after reset", v, 0);
    regRead(2'd3, v); check(v === 0, "R1", "count after reset", v, 0);

    // R2 register read-back while idle
    regWrite(2'd1, 32'h5A);
    regWrite(2'd2, 32'h100);
    regWrite(2'd3, 32'd3);
    regRead(2'd1, v); check(v === 32'h5A, "R2", "device port read-back", v, 32'h5A);
    regRead(2'd2, v); check(v === 32'h100, "R2", "memory address read-back", v, 32'h100);
    regRead(2'd3, v); check(v === 32'd3, "R2", "count read-back", v, 3);

    // Job A: device to memory, immediate grant
    grantDelay = 0;
    devReady = 1'b1;
    base = xferCount;
    launchJob(1'b0, 8'h5A, 32'h100, 3);
    regRead(2'd0, v); check(v[0] === 1'b1, "R3", "busy after start", v[0], 1);
    waitIrq("R8");
    regRead(2'd0, v); check(v[0] === 1'b0, "R8", "busy clear at completion", v[0], 0);
    regRead(2'd2, v); check(v === 32'h10C, "R7", "final memory address", v, 32'h10C);
    regRead(2'd3, v); check(v === 0, "R7", "final count", v, 0);
    check(xferCount - base == 3, "R5", "words moved in job A", xferCount - base, 3);
    repeat (20) @(negedge clk);
    check(irq === 1'b1, "R9", "interrupt held", irq, 1);
    regWrite(2'd0, 32'h4);
    check(irq === 1'b0, "R9", "interrupt cleared", irq, 0);

    // Job B: memory to device, slow grant, ready withdrawn mid-block
    grantDelay = 3;
    base = xferCount;
    launchJob(1'b1, 8'h33, 32'h2000, 6);
    regRead(2'd0, v); check(v[1] === 1'b1, "R3", "direction latched", v[1], 1);
    while (xferCount - base < 2) @(negedge clk);
    devReady = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      check(busReq === 1'b0, "R4", "no request without ready", busReq, 0);
      @(negedge clk);
    end
    regRead(2'd3, v); check(v === 32'd4, "R4", "count held without ready", v, 4);
    // R10: conflicting writes while busy
    regWrite(2'd0, 32'h1);
    regRead(2'd0, v); check(v[1:0] === 2'b11, "R10", "start while busy ignored", v[1:0], 3);
    regWrite(2'd1, 32'h77);
    regRead(2'd1, v); check(v === 32'h33, "R10", "device port write while busy", v, 32'h33);
    regWrite(2'd3, 32'd50);
    regRead(2'd3, v); check(v === 32'd4, "R10", "count write while busy", v, 4);
    regWrite(2'd2, 32'h9000);
    regRead(2'd2, v); check(v === 32'h2008, "R10", "memory write while busy", v, 32'h2008);
    devReady = 1'b1;
    waitIrq("R8");
    check(xferCount - base == 6, "R10", "words moved in job B", xferCount - base, 6);
    regRead(2'd2, v); check(v === 32'h2018, "R7", "job B final address", v, 32'h2018);
    regWrite(2'd0, 32'h4);

    // R11 zero count
    base = xferCount;
    grantDelay = 0;
    launchJob(1'b0, 8'h01, 32'h40, 0);
    check(irq === 1'b0 && busReq === 1'b0, "R11", "no irq yet one cycle after start", irq, 0);
    @(negedge clk);
    check(irq === 1'b1, "R11", "zero count interrupt", irq, 1);
    regRead(2'd0, v); check(v[0] === 1'b0, "R11", "zero count not busy", v[0], 0);
    check(xferCount == base, "R11", "no words for zero count", xferCount - base, 0);
    regRead(2'd2, v); check(v === 32'h40, "R11", "address untouched", v, 32'h40);
    regWrite(2'd0, 32'h4);

    // single word block with one-cycle grant delay
    grantDelay = 1;
    base = xferCount;
    launchJob(1'b0, 8'hC3, 32'hFFF0, 1);
    waitIrq("R8");
    check(xferCount - base == 1, "R6", "single word block", xferCount - base, 1);
    check(expQ.size() == 0, "R5", "scoreboard drained", expQ.size(), 0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule